// File: doc/BRIEF.md
# Four-Channel DMA Register File

This block is the register file that a host uses to program a four-channel DMA controller. It occupies a 16-byte I/O window that accepts both byte and 16-bit accesses. Each channel holds a 32-bit current address, a 32-bit base address, a 16-bit current count, a 16-bit base count and an 8-bit mode register. The host selects one channel at a time, and a shared 16-bit command register sits beside the channel registers. A base flag in the select register decides whether writes reach only the base copies or both the base and current copies. The same flag decides which copy is read back.

Writes are committed on the rising clock edge, and reads are combinational from the offset and access width. The direction and address-step fields of every mode register are driven out to the transfer engine, which lies outside this block.

Some channels carry 16-bit data while their upper-byte-enable input is low, so a byte-wide bus sits in front of them. For these channels, a count written by the host is in words, not bytes. Writing such a channel's mode register doubles every count copy written since the last mode write.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every address, count, mode and command register reads zero, channel 0 is selected and the base flag is 0, so the select byte reads 0x01.
- R2: A byte write at offset 0x0 takes the channel number from bits 1:0 and the base flag from bit 2. A byte read at 0x0 returns (base flag << 3) OR (1 << channel).
- R3: A 16-bit write at offset 0x4 replaces address bits 15:0 and a 16-bit write at 0x6 replaces bits 31:16, leaving the other half unchanged. Byte writes at 0x4..0x7 replace address bytes 0..3.
- R4: Reads of the address follow the same layout (16-bit at 0x4 gives bits 15:0, at 0x6 gives bits 31:16, bytes at 0x4..0x7). Reads of the address and the count return the base copy when the base flag is 1 and the current copy when it is 0.
- R5: With the base flag 0, address and count writes update both the base and the current copy. With the flag 1, only the base copy changes and the current copy keeps its value.
- R6: A 16-bit write at 0x2 loads the whole count, and byte writes at 0x2/0x3 load its low/high byte. Every count write marks each copy it updates as written.
- R7: A byte write at 0x8 loads the selected mode register. Output dir_o[2c+1:2c] follows mode bits 3:2 of channel c (0 verify, 1 I/O to memory, 2 memory to I/O, 3 invalid), and dec_o[c] follows mode bit 5 (address decrement).
- R8: A mode write to a channel marked in WIDE_CH whose ube bit is low shifts each written count copy left by one, dropping bit 15, and leaves unwritten copies unchanged. Every mode write clears both written marks of that channel.
- R9: A 16-bit access at 0xA reads or writes the full command register. Byte accesses at 0xA/0xB reach its low/high byte.
- R10: Any other 16-bit access (word index other than 1, 2, 3 or 5, that is address bits 3:1) behaves as a byte access at the same offset. The write uses data bits 7:0 and the read returns zero in bits 15:8. Unmapped offsets read zero.
- R11: Channel register accesses reach only the selected channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, committed at the rising edge |
| wide | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| addr | input | 4 | Byte offset within the window |
| wr_data | input | 16 | Write data (bits 7:0 for byte accesses) |
| rd_data | output | 16 | Combinational read data for addr/wide |
| ube | input | 4 | Upper-byte-enable per channel |
| dir_o | output | 8 | Direction field of each channel's mode |
| dec_o | output | 4 | Address-decrement bit of each channel's mode |

## Verification
A write takes effect at the first rising edge after wr_en is raised, and read data is a combinational function of the registers, the offset and the access width. The bench therefore drives each write at a falling edge and drops wr_en at the next falling edge. It applies reads only after that, and samples rd_data one nanosecond after it applies the offset. A count doubling appears at the same edge that commits the mode write, so every readback sweep that follows a mode write already sees the doubled count. The dir_o and dec_o outputs are checked after the write edge in the same way.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NCH = 4,
  parameter int AW = 32,
  parameter int CW = 16,
  parameter logic [NCH-1:0] WIDE_CH = 4'b1010
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wide,
  input  logic [3:0]      addr,
  input  logic [15:0]     wr_data,
  output logic [15:0]     rd_data,
  input  logic [NCH-1:0]  ube,
  output logic [2*NCH-1:0] dir_o,
  output logic [NCH-1:0]  dec_o
);
  localparam int SW = $clog2(NCH);

  logic [AW-1:0] cur_adr [NCH];
  logic [AW-1:0] bas_adr [NCH];
  logic [CW-1:0] cur_cnt [NCH];
  logic [CW-1:0] bas_cnt [NCH];
  logic [7:0]    mode_q  [NCH];
  logic [NCH-1:0] fc, fb;
  logic [15:0]   cmd_q;
  logic [SW-1:0] sel_q;
  logic          base_q;

  logic [2:0] word;
  logic w_cnt, w_alo, w_ahi, w_cmd, byte_acc;
  logic sel_hit, cnt_hit, adr_hit, mode_hit, cmd_hit, fix;

  assign word     = addr[3:1];
  assign w_cnt    = wide && word == 3'd1;
  assign w_alo    = wide && word == 3'd2;
  assign w_ahi    = wide && word == 3'd3;
  assign w_cmd    = wide && word == 3'd5;
  assign byte_acc = !(w_cnt || w_alo || w_ahi || w_cmd);
  assign sel_hit  = byte_acc && addr == 4'h0;
  assign cnt_hit  = w_cnt || (byte_acc && word == 3'd1);
  assign adr_hit  = w_alo || w_ahi || (byte_acc && addr[3:2] == 2'b01);
  assign mode_hit = byte_acc && addr == 4'h8;
  assign cmd_hit  = w_cmd || (byte_acc && word == 3'd5);
  assign fix      = WIDE_CH[sel_q] && !ube[sel_q];

  logic [AW-1:0] nxt_ca, nxt_ba;
  logic [CW-1:0] nxt_cc, nxt_bc;

  always_comb begin
    nxt_ca = cur_adr[sel_q];
    nxt_ba = bas_adr[sel_q];
    if (w_alo) begin
      nxt_ca[15:0] = wr_data;
      nxt_ba[15:0] = wr_data;
    end else if (w_ahi) begin
      nxt_ca[31:16] = wr_data;
      nxt_ba[31:16] = wr_data;
    end else begin
      nxt_ca[{addr[1:0], 3'b000} +: 8] = wr_data[7:0];
      nxt_ba[{addr[1:0], 3'b000} +: 8] = wr_data[7:0];
    end
    nxt_cc = cur_cnt[sel_q];
    nxt_bc = bas_cnt[sel_q];
    if (w_cnt) begin
      nxt_cc = wr_data;
      nxt_bc = wr_data;
    end else begin
      nxt_cc[{addr[0], 3'b000} +: 8] = wr_data[7:0];
      nxt_bc[{addr[0], 3'b000} +: 8] = wr_data[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        cur_adr[i] <= '0;
        bas_adr[i] <= '0;
        cur_cnt[i] <= '0;
        bas_cnt[i] <= '0;
        mode_q[i]  <= '0;
      end
      fc     <= '0;
      fb     <= '0;
      cmd_q  <= '0;
      sel_q  <= '0;
      base_q <= 1'b0;
    end else if (wr_en) begin
      if (sel_hit) begin
        sel_q  <= wr_data[SW-1:0];
        base_q <= wr_data[2];
      end
      if (cmd_hit) begin
        if (w_cmd) cmd_q <= wr_data;
        else       cmd_q[{addr[0], 3'b000} +: 8] <= wr_data[7:0];
      end
      if (adr_hit) begin
        bas_adr[sel_q] <= nxt_ba;
        if (!base_q) cur_adr[sel_q] <= nxt_ca;
      end
      if (cnt_hit) begin
        bas_cnt[sel_q] <= nxt_bc;
        fb[sel_q] <= 1'b1;
        if (!base_q) begin
          cur_cnt[sel_q] <= nxt_cc;
          fc[sel_q] <= 1'b1;
        end
      end
      if (mode_hit) begin
        mode_q[sel_q] <= wr_data[7:0];
        fc[sel_q] <= 1'b0;
        fb[sel_q] <= 1'b0;
        if (fix) begin
          if (fc[sel_q]) cur_cnt[sel_q] <= cur_cnt[sel_q] << 1;
          if (fb[sel_q]) bas_cnt[sel_q] <= bas_cnt[sel_q] << 1;
        end
      end
    end
  end

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_mode_out
      assign dir_o[2*c +: 2] = mode_q[c][3:2];
      assign dec_o[c]        = mode_q[c][5];
    end
  endgenerate

  logic [AW-1:0] ra;
  logic [CW-1:0] rc;
  logic [7:0]    rbyte, sel_byte;

  assign ra       = base_q ? bas_adr[sel_q] : cur_adr[sel_q];
  assign rc       = base_q ? bas_cnt[sel_q] : cur_cnt[sel_q];
  assign sel_byte = (8'(base_q) << 3) | (8'(1) << sel_q);

  always_comb begin
    case (addr)
      4'h0:    rbyte = sel_byte;
      4'h2:    rbyte = rc[7:0];
      4'h3:    rbyte = rc[15:8];
      4'h4:    rbyte = ra[7:0];
      4'h5:    rbyte = ra[15:8];
      4'h6:    rbyte = ra[23:16];
      4'h7:    rbyte = ra[31:24];
      4'h8:    rbyte = mode_q[sel_q];
      4'hA:    rbyte = cmd_q[7:0];
      4'hB:    rbyte = cmd_q[15:8];
      default: rbyte = 8'h00;
    endcase
    if (w_cnt)      rd_data = rc;
    else if (w_alo) rd_data = ra[15:0];
    else if (w_ahi) rd_data = ra[31:16];
    else if (w_cmd) rd_data = cmd_q;
    else            rd_data = {8'h00, rbyte};
  end

  p_keep_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && w_alo |=> bas_adr[sel_q][31:16] == $past(bas_adr[sel_q][31:16]));

  p_keep_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && w_ahi |=> bas_adr[sel_q][15:0] == $past(bas_adr[sel_q][15:0]));

  p_base_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && base_q && adr_hit |=> $stable(cur_adr[sel_q]));

  p_cnt_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && cnt_hit |=> fb[sel_q]);

  p_mark_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && mode_hit |=> !fc[sel_q] && !fb[sel_q]);

  p_double_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && mode_hit && fix && fc[sel_q] |=> cur_cnt[sel_q] == {$past(cur_cnt[sel_q][CW-2:0]), 1'b0});

  p_hi_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_acc |-> rd_data[15:8] == 8'h00);
endmodule

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wide = 1'b0;
  logic [3:0] addr = 4'h0, ube = 4'h0;
  logic [15:0] wr_data = 16'h0, rd_data;
  logic [7:0] dir_o;
  logic [3:0] dec_o;
  int n_chk = 0, n_fail = 0;
  localparam logic [3:0] WIDE = 4'b1010;

  always #2.5 clk = ~clk;

  dma_chan_regs dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wide(wide),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .ube(ube),
    .dir_o(dir_o), .dec_o(dec_o));

  logic [31:0] m_ca [4], m_ba [4];
  logic [15:0] m_cc [4], m_bc [4];
  logic [7:0]  m_md [4];
  logic [3:0]  m_fc, m_fb;
  logic [15:0] m_cmd;
  int m_sel;
  logic m_base;

  task automatic m_reset();
    for (int i = 0; i < 4; i++) begin
      m_ca[i] = 0; m_ba[i] = 0; m_cc[i] = 0; m_bc[i] = 0; m_md[i] = 0;
    end
    m_fc = 0; m_fb = 0; m_cmd = 0; m_sel = 0; m_base = 0;
  endtask

  task automatic m_write(input logic [3:0] a, input logic w, input logic [15:0] d);
    int s = m_sel;
    int wd = a[3:1];
    int sh;
    if (w && wd == 1) begin
      m_bc[s] = d; m_fb[s] = 1;
      if (!m_base) begin m_cc[s] = d; m_fc[s] = 1; end
    end else if (w && (wd == 2 || wd == 3)) begin
      sh = (wd == 2) ? 0 : 16;
      m_ba[s] = (m_ba[s] & ~(32'hFFFF << sh)) | (32'(d) << sh);
      if (!m_base) m_ca[s] = (m_ca[s] & ~(32'hFFFF << sh)) | (32'(d) << sh);
    end else if (w && wd == 5) begin
      m_cmd = d;
    end else begin
      case (a)
        4'h0: begin m_sel = int'(d[1:0]); m_base = d[2]; end
        4'h2, 4'h3: begin
          sh = (a == 4'h3) ? 8 : 0;
          m_bc[s] = (m_bc[s] & ~(16'hFF << sh)) | (16'(d[7:0]) << sh); m_fb[s] = 1;
          if (!m_base) begin
            m_cc[s] = (m_cc[s] & ~(16'hFF << sh)) | (16'(d[7:0]) << sh); m_fc[s] = 1;
          end
        end
        4'h4, 4'h5, 4'h6, 4'h7: begin
          sh = 8 * (int'(a) - 4);
          m_ba[s] = (m_ba[s] & ~(32'hFF << sh)) | (32'(d[7:0]) << sh);
          if (!m_base) m_ca[s] = (m_ca[s] & ~(32'hFF << sh)) | (32'(d[7:0]) << sh);
        end
        4'h8: begin
          m_md[s] = d[7:0];
          if (WIDE[s] && !ube[s]) begin
            if (m_fc[s]) m_cc[s] = m_cc[s] * 2;
            if (m_fb[s]) m_bc[s] = m_bc[s] * 2;
          end
          m_fc[s] = 0; m_fb[s] = 0;
        end
        4'hA: m_cmd[7:0] = d[7:0];
        4'hB: m_cmd[15:8] = d[7:0];
        default: ;
      endcase
    end
  endtask

  function automatic logic [15:0] m_read(input logic [3:0] a, input logic w);
    logic [31:0] ad = m_base ? m_ba[m_sel] : m_ca[m_sel];
    logic [15:0] ct = m_base ? m_bc[m_sel] : m_cc[m_sel];
    int wd = a[3:1];
    if (w && wd == 1) return ct;
    if (w && wd == 2) return ad[15:0];
    if (w && wd == 3) return ad[31:16];
    if (w && wd == 5) return m_cmd;
    case (a)
      4'h0: return 16'((int'(m_base) * 8) | (1 << m_sel));
      4'h2: return {8'h0, ct[7:0]};
      4'h3: return {8'h0, ct[15:8]};
      4'h4, 4'h5, 4'h6, 4'h7: return 16'((ad >> (8 * (int'(a) - 4))) & 32'hFF);
      4'h8: return {8'h0, m_md[m_sel]};
      4'hA: return {8'h0, m_cmd[7:0]};
      4'hB: return {8'h0, m_cmd[15:8]};
      default: return 16'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a, input logic w);
    int wd = a[3:1];
    if (w && wd == 1) return "R6";
    if (w && (wd == 2 || wd == 3)) return "R3/R4";
    if (w && wd == 5) return "R9";
    if (w) return "R10";
    case (a)
      4'h0: return "R2";
      4'h2, 4'h3: return "R6";
      4'h4, 4'h5, 4'h6, 4'h7: return "R4";
      4'h8: return "R7";
      4'hA, 4'hB: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic w, input logic [15:0] d);
    @(negedge clk);
    addr = a; wide = w; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    m_write(a, w, d);
  endtask

  task automatic sweep(input string ctx);
    for (int a = 0; a < 16; a++) begin
      for (int w = 0; w < 2; w++) begin
        addr = 4'(a); wide = w[0];
        #1;
        check($sformatf("%s %s off=%0h wide=%0d", ctx, tag_of(4'(a), w[0]), a, w),
              rd_data, m_read(4'(a), w[0]));
      end
    end
  endtask

  task automatic check_mode_outs(input string ctx);
    for (int c = 0; c < 4; c++) begin
      check({ctx, " R7 dir"}, 16'(dir_o[2*c +: 2]), 16'(m_md[c][3:2]));
      check({ctx, " R7 dec"}, 16'(dec_o[c]), 16'(m_md[c][5]));
    end
  endtask

  task automatic select(input int ch, input logic bs);
    wr(4'h0, 1'b0, 16'((int'(bs) << 2) | ch));
  endtask

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R1 reset");
    addr = 4'h0; wide = 1'b0; #1;
    check("R1 select byte after reset", rd_data, 16'h0001);
    check_mode_outs("R1");

    for (int pass = 0; pass < 2; pass++) begin
      ube = (pass == 0) ? 4'b0101 : 4'b1111;
      for (int ch = 0; ch < 4; ch++) begin
        select(ch, 1'b0);
        wr(4'h2, 1'b1, 16'h1357 + 16'(ch * 16'h0111 + pass));
        wr(4'h4, 1'b1, 16'hA5C3 ^ 16'(ch * 16'h1001));
        wr(4'h6, 1'b1, 16'h7E10 + 16'(ch));
        wr(4'h5, 1'b0, 16'hFF00 | 16'(8'h30 + ch));
        sweep("R5 R11 base=0 writes");
        select(ch, 1'b1);
        wr(4'h3, 1'b0, 16'(8'h40 + ch));
        wr(4'h7, 1'b0, 16'(8'hC0 | ch));
        wr(4'h4, 1'b1, 16'h0F0F + 16'(ch));
        sweep("R5 base=1 view");
        select(ch, 1'b0);
        sweep("R5 current copy unchanged");
        select(ch, 1'b1);
        wr(4'h8, 1'b0, 16'((ch << 2) | ((ch & 1) << 5) | pass));
        sweep("R8 base view after mode");
        select(ch, 1'b0);
        sweep("R8 current view after mode");
        check_mode_outs("R7 R11");
        wr(4'h8, 1'b0, 16'((ch << 2) | ((ch & 1) << 5) | 2));
        sweep("R8 marks cleared, no re-double");
        select(ch, 1'b1);
        wr(4'h2, 1'b0, 16'h00C1);
        wr(4'h8, 1'b0, 16'(((3 - ch) << 2) | (((ch + 1) & 1) << 5)));
        sweep("R8 base-only mark");
        select(ch, 1'b0);
        sweep("R8 current unmarked");
        check_mode_outs("R7");
      end
    end

    select(2, 1'b0);
    wr(4'hA, 1'b1, 16'hBEEF);
    sweep("R9 wide cmd");
    wr(4'hB, 1'b0, 16'h1234);
    sweep("R9 byte cmd");
    wr(4'h8, 1'b1, 16'hAB2C);
    sweep("R10 wide fallback mode");
    check_mode_outs("R10");
    wr(4'hE, 1'b1, 16'hFFFF);
    sweep("R10 unmapped");
    wr(4'h1, 1'b1, 16'h5A07);
    sweep("R10 wide fallback odd offset");
    wr(4'h0, 1'b1, 16'hFF07);
    sweep("R10 R2 wide fallback select");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule